// File: doc/BRIEF.md
# Three-Phase Bridge Gate Sequencer

The block turns per-phase drive requests from a commutation stage into the six gate commands of a three-phase MOSFET bridge: one high-side and one low-side gate for each phase. Each phase has its own small state machine. The machine never turns a gate on until a programmable dead time has elapsed since the last turn-off in that phase. This holds when the requested side changes, on PWM edges, when recirculation starts, and when the brake or coast override takes over.

During the PWM-off interval the block recirculates the load current through transistors rather than through body diodes. In slow decay every driven phase moves to its low side. In fast decay every driven phase moves to its opposite side, and those phases are switched off once the zero-current flag rises, so the current cannot reverse. Brake drives all low sides on and all high sides off. Coast turns all six gates off and takes priority over brake. Every turn-on restarts a blanking window, and while that window runs the current-trip comparator input is masked. The dead-time and blank lengths are cycle-count registers. They accept a new value only while every phase is idle.

Per-phase states are `PH_OFF`, `PH_HIGH`, `PH_LOW` and `PH_DEAD`. The transitions are:
- `PH_OFF` to `PH_HIGH` or `PH_LOW`: the phase turns on.
- `PH_HIGH` or `PH_LOW` to `PH_DEAD`: the phase turns off.
- `PH_DEAD` to `PH_HIGH`, `PH_LOW` or `PH_OFF`: the dead time has expired and the phase settles on its current target.

Each phase's target comes from a drive mode. The modes are `MD_COAST`, `MD_BRAKE`, `MD_FLOAT`, `MD_DRIVE` and `MD_RECIRC`, listed from highest to lowest priority.

Top module: `bridge_gate_seq`

## Requirements
- R1: After reset all six gates are off, and `trip_ok` follows `trip_in`, because no blanking window is running.
- R2: With PWM on, each phase follows its 2-bit command code. Code 2'b10 turns the high gate on. Code 2'b01 turns the low gate on. Codes 2'b00 and 2'b11 mean floating, with both gates off. The code for phase p is `cmd[2p+1:2p]`, and bit 0 of `gate_hi` and `gate_lo` is phase A. A phase starting from idle turns on in the first cycle after the request.
- R3: After a gate of a phase turns off, both gates of that phase stay off for exactly D cycles before either gate turns on. D is the dead-time register value, and a value of 0 acts as 1.
- R4: After reset the dead-time register holds 2^DT_W-1, which is 1023 by default.
- R5: With PWM off and `decay_fast`=0, a phase commanded high moves to its low side after the dead time. A phase commanded low stays low.
- R6: With PWM off and `decay_fast`=1, each driven phase moves to its opposite side after the dead time. While `zero_cur`=1, those phases turn both gates off in the first cycle.
- R7: With `brake`=1, every high gate is off in the first cycle, and every low gate is on once its dead time ends.
- R8: With `coast`=1, all six gates are off in the first cycle, whatever the state of `brake`.
- R9: After any gate turns on, `trip_ok` stays 0 for B cycles, where B is the blank register value. After that it follows `trip_in`.
- R10: `cfg_we` loads `cfg_dead` and `cfg_blank` only when every phase is off and not inside a dead time. At any other time the write is ignored.
- R11: The high and low gates of one phase are never on together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd | input | 2*PHASES | Per-phase drive code: 10 high, 01 low, 00/11 float |
| pwm_on | input | 1 | 1 = PWM on-time, 0 = recirculation |
| decay_fast | input | 1 | 1 = fast decay, 0 = slow decay |
| zero_cur | input | 1 | Load current has reached zero |
| brake | input | 1 | Dynamic brake request |
| coast | input | 1 | All-off request, overrides brake |
| trip_in | input | 1 | Current-trip comparator input |
| cfg_we | input | 1 | Write strobe for the timing registers |
| cfg_dead | input | DT_W | Dead time in cycles |
| cfg_blank | input | BL_W | Blank time in cycles |
| gate_hi | output | PHASES | High-side gate commands |
| gate_lo | output | PHASES | Low-side gate commands |
| trip_ok | output | 1 | Trip input after blanking |

## Verification
The dead-gap assertion assumes that the phase has been on at least once since reset. It also assumes that the dead time applied is the register value at the moment of turn-off, even if the register is rewritten later while the phase is idle. The bench only writes the registers while every phase is idle, except for one deliberate write during an active phase, which checks R10. The assertions take the inputs as stable within a cycle, and the bench changes inputs only just after the falling clock edge. The bench waits longer than the dead time before each pattern check, so every transition has settled.

// File: rtl/bgs_pkg.sv
package bgs_pkg;
    typedef enum logic [1:0] {TGT_OFF, TGT_HI, TGT_LO} tgt_e;
    typedef enum logic [1:0] {PH_OFF, PH_DEAD, PH_HIGH, PH_LOW} ph_st_e;
    typedef enum logic [2:0] {MD_COAST, MD_BRAKE, MD_FLOAT, MD_DRIVE, MD_RECIRC} drv_mode_e;
endpackage

// File: rtl/bgs_target_map.sv
module bgs_target_map
    import bgs_pkg::*;
(
    input  logic [1:0] code,
    input  logic       pwm_on,
    input  logic       decay_fast,
    input  logic       zero_cur,
    input  logic       brake,
    input  logic       coast,
    output tgt_e       tgt
);
    drv_mode_e mode;
    logic      drive_hi;
    logic      floating;

    assign drive_hi = (code == 2'b10);
    assign floating = (code == 2'b00) || (code == 2'b11);

    // Mode priority: coast, brake, float, drive, recirculation
    always_comb begin
        if (coast)          mode = MD_COAST;
        else if (brake)     mode = MD_BRAKE;
        else if (floating)  mode = MD_FLOAT;
        else if (pwm_on)    mode = MD_DRIVE;
        else                mode = MD_RECIRC;
    end

    always_comb begin
        tgt = TGT_OFF;
        unique case (mode)
            MD_COAST:  tgt = TGT_OFF;
            MD_BRAKE:  tgt = TGT_LO;
            MD_FLOAT:  tgt = TGT_OFF;
            MD_DRIVE:  tgt = drive_hi ? TGT_HI : TGT_LO;
            MD_RECIRC: begin
                if (!decay_fast)   tgt = TGT_LO;
                else if (zero_cur) tgt = TGT_OFF;
                else               tgt = drive_hi ? TGT_LO : TGT_HI;
            end
            default:   tgt = TGT_OFF;
        endcase
    end
endmodule

// File: rtl/bgs_phase_fsm.sv
module bgs_phase_fsm
    import bgs_pkg::*;
#(
    parameter int DT_W = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  tgt_e            tgt,
    input  logic [DT_W-1:0] dead,
    output logic            gate_hi,
    output logic            gate_lo,
    output logic            ph_idle,
    output logic            turn_on
);
    ph_st_e          st, nxt;
    logic [DT_W-1:0] cnt;
    logic [DT_W-1:0] dead_eff;

    assign dead_eff = (dead == '0) ? DT_W'(1) : dead;

    function automatic ph_st_e settle(input tgt_e t);
        case (t)
            TGT_HI:  return PH_HIGH;
            TGT_LO:  return PH_LOW;
            default: return PH_OFF;
        endcase
    endfunction

    always_comb begin
        nxt = st;
        unique case (st)
            PH_OFF:  nxt = settle(tgt);
            PH_HIGH: if (tgt != TGT_HI) nxt = PH_DEAD;
            PH_LOW:  if (tgt != TGT_LO) nxt = PH_DEAD;
            PH_DEAD: if (cnt == '0) nxt = settle(tgt);
            default: nxt = PH_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= PH_OFF;
            cnt <= '0;
        end else begin
            st <= nxt;
            if (nxt == PH_DEAD && st != PH_DEAD)
                cnt <= dead_eff - DT_W'(1);
            else if (st == PH_DEAD && cnt != '0)
                cnt <= cnt - DT_W'(1);
        end
    end

    always_comb begin
        gate_hi = (st == PH_HIGH);
        gate_lo = (st == PH_LOW);
        ph_idle = (st == PH_OFF);
        turn_on = ((nxt == PH_HIGH) && (st != PH_HIGH)) ||
                  ((nxt == PH_LOW)  && (st != PH_LOW));
    end

    // Checker state: length of the current all-off run and dead time used at turn-off
    logic [DT_W-1:0] off_run;
    logic [DT_W-1:0] dead_at_off;
    logic            had_on;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off_run     <= '0;
            dead_at_off <= '0;
            had_on      <= 1'b0;
        end else begin
            if (gate_hi || gate_lo) begin
                off_run <= '0;
                had_on  <= 1'b1;
            end else if (off_run != '1) begin
                off_run <= off_run + DT_W'(1);
            end
            if ((st == PH_HIGH || st == PH_LOW) && nxt == PH_DEAD)
                dead_at_off <= dead_eff;
        end
    end

    a_r11_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_hi && gate_lo));

    a_r3_dead_gap: assert property (@(posedge clk) disable iff (!rst_n)
        ((gate_hi || gate_lo) && !$past(gate_hi || gate_lo) && had_on)
        |-> (off_run >= dead_at_off));
endmodule

// File: rtl/bgs_blank_timer.sv
module bgs_blank_timer #(
    parameter int BL_W = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [BL_W-1:0] len,
    input  logic            trip_in,
    output logic            trip_ok
);
    logic [BL_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (start)      cnt <= len;
        else if (cnt != '0)  cnt <= cnt - BL_W'(1);
    end

    assign trip_ok = trip_in && (cnt == '0);

    a_r9_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (start && len != '0) |=> !trip_ok);
endmodule

// File: rtl/bridge_gate_seq.sv
module bridge_gate_seq
    import bgs_pkg::*;
#(
    parameter int PHASES    = 3,
    parameter int DT_W      = 10,
    parameter int BL_W      = 6,
    parameter int BLANK_RST = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2*PHASES-1:0] cmd,
    input  logic              pwm_on,
    input  logic              decay_fast,
    input  logic              zero_cur,
    input  logic              brake,
    input  logic              coast,
    input  logic              trip_in,
    input  logic              cfg_we,
    input  logic [DT_W-1:0]   cfg_dead,
    input  logic [BL_W-1:0]   cfg_blank,
    output logic [PHASES-1:0] gate_hi,
    output logic [PHASES-1:0] gate_lo,
    output logic              trip_ok
);
    localparam logic [DT_W-1:0] DEAD_RST = '1;
    localparam logic [BL_W-1:0] BLK_RST  = BL_W'(BLANK_RST);

    logic [DT_W-1:0]   dead_reg;
    logic [BL_W-1:0]   blank_reg;
    logic [PHASES-1:0] ph_idle;
    logic [PHASES-1:0] ph_on;
    logic              all_idle;

    assign all_idle = &ph_idle;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dead_reg  <= DEAD_RST;
            blank_reg <= BLK_RST;
        end else if (cfg_we && all_idle) begin
            dead_reg  <= cfg_dead;
            blank_reg <= cfg_blank;
        end
    end

    for (genvar p = 0; p < PHASES; p++) begin : g_phase
        tgt_e tgt;

        bgs_target_map u_map (
            .code       (cmd[2*p +: 2]),
            .pwm_on     (pwm_on),
            .decay_fast (decay_fast),
            .zero_cur   (zero_cur),
            .brake      (brake),
            .coast      (coast),
            .tgt        (tgt)
        );

        bgs_phase_fsm #(.DT_W(DT_W)) u_fsm (
            .clk     (clk),
            .rst_n   (rst_n),
            .tgt     (tgt),
            .dead    (dead_reg),
            .gate_hi (gate_hi[p]),
            .gate_lo (gate_lo[p]),
            .ph_idle (ph_idle[p]),
            .turn_on (ph_on[p])
        );
    end

    bgs_blank_timer #(.BL_W(BL_W)) u_blank (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (|ph_on),
        .len     (blank_reg),
        .trip_in (trip_in),
        .trip_ok (trip_ok)
    );

    a_r8_coast_off: assert property (@(posedge clk) disable iff (!rst_n)
        coast |=> (gate_hi == '0) && (gate_lo == '0));

    a_r7_brake_hi_off: assert property (@(posedge clk) disable iff (!rst_n)
        (brake && !coast) |=> (gate_hi == '0));

    a_r10_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !all_idle) |=> $stable(dead_reg) && $stable(blank_reg));
endmodule

// File: tb/bridge_gate_seq_bench.sv
module bridge_gate_seq_bench;
    localparam int PHASES = 3;
    localparam int DT_W   = 10;
    localparam int BL_W   = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [2*PHASES-1:0] cmd = '0;
    logic              pwm_on = 1'b0, decay_fast = 1'b0, zero_cur = 1'b0;
    logic              brake = 1'b0, coast = 1'b0, trip_in = 1'b0, cfg_we = 1'b0;
    logic [DT_W-1:0]   cfg_dead = '0;
    logic [BL_W-1:0]   cfg_blank = '0;
    logic [PHASES-1:0] gate_hi, gate_lo;
    logic              trip_ok;

    int n_tests = 0;
    int n_fail  = 0;
    int overlap = 0;

    always #5 clk = ~clk;

    bridge_gate_seq #(.PHASES(PHASES), .DT_W(DT_W), .BL_W(BL_W)) u_bridge_gate_seq (
        .clk(clk), .rst_n(rst_n), .cmd(cmd), .pwm_on(pwm_on), .decay_fast(decay_fast),
        .zero_cur(zero_cur), .brake(brake), .coast(coast), .trip_in(trip_in),
        .cfg_we(cfg_we), .cfg_dead(cfg_dead), .cfg_blank(cfg_blank),
        .gate_hi(gate_hi), .gate_lo(gate_lo), .trip_ok(trip_ok)
    );

    always @(negedge clk) if ((gate_hi & gate_lo) != '0) overlap++;

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    // Count cycles with both phase-A gates off until one turns on
    task automatic gap_a(output int n);
        n = 0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (gate_hi[0] || gate_lo[0]) break;
            n++;
        end
    endtask

    task automatic load_cfg(input int d, input int b);
        cfg_dead = DT_W'(d); cfg_blank = BL_W'(b); cfg_we = 1'b1;
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic t_reset();
        tick(3);
        rst_n = 1'b1;
        tick();
        chk("R1 gate_hi after reset", int'(gate_hi), 0);
        chk("R1 gate_lo after reset", int'(gate_lo), 0);
        trip_in = 1'b1; #1;
        chk("R1 trip_ok follows trip_in", int'(trip_ok), 1);
        trip_in = 1'b0;
    endtask

    task automatic t_default_dead();
        int n;
        pwm_on = 1'b1; cmd = 6'b000010;
        tick();
        chk("R2 phase A high from idle", int'(gate_hi), 1);
        cmd = 6'b000001;
        gap_a(n);
        chk("R4 default dead time", n, 1023);
        chk("R4 low side on after dead", int'(gate_lo[0]), 1);
        cmd = '0;
        tick(1030);
    endtask

    task automatic t_cfg_guard();
        int n;
        load_cfg(4, 3);
        cmd = 6'b000010;
        tick();
        cmd = 6'b000001; cfg_dead = 10'd9; cfg_blank = 6'd9; cfg_we = 1'b1;
        gap_a(n);
        cfg_we = 1'b0;
        chk("R3 dead gap of 4", n, 4);
        cmd = '0; tick(10);
        cmd = 6'b000010; tick();
        cmd = 6'b000001;
        gap_a(n);
        chk("R10 busy write ignored", n, 4);
        cmd = '0; tick(10);
    endtask

    task automatic t_zero_dead();
        int n;
        load_cfg(0, 3);
        cmd = 6'b000010; tick();
        cmd = 6'b000001;
        gap_a(n);
        chk("R3 zero dead acts as one", n, 1);
        cmd = '0; tick(5);
        load_cfg(4, 3);
    endtask

    task automatic t_drive();
        cmd = 6'b000110; tick();
        chk("R2 high pattern", int'(gate_hi), 1);
        chk("R2 low pattern", int'(gate_lo), 2);
        cmd = 6'b110110; tick(2);
        chk("R2 code 11 floats C hi", int'(gate_hi), 1);
        chk("R2 code 11 floats C lo", int'(gate_lo), 2);
    endtask

    task automatic t_slow();
        pwm_on = 1'b0; decay_fast = 1'b0; tick(8);
        chk("R5 slow decay hi", int'(gate_hi), 0);
        chk("R5 slow decay lo", int'(gate_lo), 3);
        pwm_on = 1'b1; tick(8);
        chk("R5 back to drive hi", int'(gate_hi), 1);
    endtask

    task automatic t_fast();
        pwm_on = 1'b0; decay_fast = 1'b1; tick(8);
        chk("R6 fast decay hi", int'(gate_hi), 2);
        chk("R6 fast decay lo", int'(gate_lo), 1);
        zero_cur = 1'b1; tick();
        chk("R6 zero current hi off", int'(gate_hi), 0);
        chk("R6 zero current lo off", int'(gate_lo), 0);
        tick(8);
        chk("R6 zero current stays off", int'(gate_hi | gate_lo), 0);
        zero_cur = 1'b0; pwm_on = 1'b1; tick(8);
    endtask

    task automatic t_brake_coast();
        brake = 1'b1; tick();
        chk("R7 brake high sides off at once", int'(gate_hi), 0);
        tick(8);
        chk("R7 brake all low on", int'(gate_lo), 7);
        coast = 1'b1; tick();
        chk("R8 coast over brake lo", int'(gate_lo), 0);
        chk("R8 coast over brake hi", int'(gate_hi), 0);
        tick(8);
        chk("R8 coast holds off", int'(gate_hi | gate_lo), 0);
        coast = 1'b0; brake = 1'b0; cmd = '0; tick(10);
    endtask

    task automatic t_blank();
        int n = 0;
        trip_in = 1'b1;
        cmd = 6'b000010; tick();
        for (int i = 0; i < 100; i++) begin
            if (trip_ok) break;
            n++;
            tick();
        end
        chk("R9 blank window length", n, 3);
        tick(2);
        chk("R9 trip passes after blank", int'(trip_ok), 1);
        trip_in = 1'b0; #1;
        chk("R9 trip follows input", int'(trip_ok), 0);
        cmd = '0; tick(10);
    endtask

    initial begin
        t_reset();
        t_default_dead();
        t_cfg_guard();
        t_zero_dead();
        t_drive();
        t_slow();
        t_fast();
        t_brake_coast();
        t_blank();
        chk("R11 no same-phase overlap", overlap, 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule